// File: doc/BRIEF.md
# PCM Bypass and Reset Sequencer

This block sets the operating state of a two-port PCM echo-canceller datapath. It turns an active-low power-down input into gated clock enables and high-impedance output enables. It runs a start-up window measured in whole 8 kHz frames and refuses register writes until that window ends. It also holds a small mode register with a bypass bit and an adapt-freeze bit. The receive port (Rin to Rout) and the send port (Sin to Sout) each carry one voice byte and one control byte per frame. A frame strobe marks each frame.

In normal operation each voice byte passes through a delay line that is two frames long. Each control byte passes through a delay line that is one frame long. The cancellation arithmetic is outside this block and sits between these delay stages. When bypass is set, each output copies its input in the same cycle, bit for bit. The processing clock enables are then turned off and only the pass-through enable stays on.

Top module: `pcm_bypass_seq`

## Requirements
- R1: At every rising clk edge where dev_rst_n is low, the next state is as follows: rout_oe and sout_oe are 0, all four data outputs are 0, proc_clk_en, adapt_en and pass_clk_en are 0, and init_busy is 1.
- R2: After release, init_busy stays 1 and the mode register keeps its default 2'b00. The first frame_stb only opens the count; init_busy falls at the edge of the strobe that completes the 8th whole frame, which is the 9th strobe after release.
- R3: While init_busy is 1, wr_ack is 0 and a write request leaves the mode register unchanged.
- R4: While init_busy is 0, wr_ack follows wr_req in the same cycle, and an accepted write loads wr_data at the clock edge. Bit 0 is bypass and bit 1 is adapt-freeze.
- R5: With bypass set, rout_voice/rout_ctrl equal rin_voice/rin_ctrl and sout_voice/sout_ctrl equal sin_voice/sin_ctrl in the same cycle.
- R6: With bypass set, proc_clk_en and adapt_en are 0 while pass_clk_en stays 1.
- R7: In normal mode, a voice byte sampled at strobe edge n appears on its output right after strobe edge n+2 and holds until the next strobe. After reset the line holds zeros.
- R8: In normal mode, a control byte sampled at strobe edge n appears on its output right after strobe edge n+1 and holds until the next strobe.
- R9: With freeze set and bypass clear, adapt_en is 0 and proc_clk_en is 1, and the delay lines keep running as in R7 and R8.
- R10: From the first clock edge with dev_rst_n high, rout_oe, sout_oe and pass_clk_en are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| dev_rst_n | input | 1 | Synchronous active-low reset / power-down |
| frame_stb | input | 1 | One-cycle pulse at each frame boundary |
| wr_req | input | 1 | Mode register write request |
| wr_data | input | 2 | Write data: bit1 freeze, bit0 bypass |
| rin_voice | input | 8 | Receive-port voice byte in |
| rin_ctrl | input | 8 | Receive-port control byte in |
| sin_voice | input | 8 | Send-port voice byte in |
| sin_ctrl | input | 8 | Send-port control byte in |
| rout_voice | output | 8 | Receive-port voice byte out |
| rout_ctrl | output | 8 | Receive-port control byte out |
| rout_oe | output | 1 | Receive output enable (0 = high impedance) |
| sout_voice | output | 8 | Send-port voice byte out |
| sout_ctrl | output | 8 | Send-port control byte out |
| sout_oe | output | 1 | Send output enable (0 = high impedance) |
| wr_ack | output | 1 | Write accepted this cycle |
| init_busy | output | 1 | Start-up window in progress |
| proc_clk_en | output | 1 | Clock enable for the processing logic |
| adapt_en | output | 1 | Filter-update enable |
| pass_clk_en | output | 1 | Clock enable for the pass-through paths |

## Verification
The assertions assume that frame_stb is a single-cycle pulse and that frames are many cycles apart. They also assume that wr_req is asserted only for a single cycle before it is sampled. The bench drives frame_stb high for exactly one cycle in every six-cycle frame. It changes inputs only on falling edges and never writes the mode register in the same cycle as a strobe. The bench predicts the delay lines only while bypass is clear, because bypass freezes them. After every reset it refills its expected queues with zeros.

// File: rtl/pcm_seq_pkg.sv
package pcm_seq_pkg;

    localparam int BYTE_W      = 8;
    localparam int INIT_FRAMES = 8;
    localparam int VOICE_LAG   = 2;
    localparam int CTRL_LAG    = 1;

    typedef enum logic [1:0] {
        SQ_OFF,
        SQ_SYNC,
        SQ_COUNT,
        SQ_READY
    } seq_state_e;

    typedef struct packed {
        logic freeze;
        logic bypass;
    } mode_reg_t;

    localparam mode_reg_t MODE_DEFAULT = '{freeze: 1'b0, bypass: 1'b0};

    function automatic mode_reg_t unpack_mode(input logic [1:0] w);
        return mode_reg_t'(w);
    endfunction

endpackage

// File: rtl/init_seq.sv
module init_seq
    import pcm_seq_pkg::*;
#(
    parameter int FRAMES = INIT_FRAMES
) (
    input  logic clk,
    input  logic dev_rst_n,
    input  logic frame_stb,
    output logic run_q,
    output logic init_busy
);
    localparam int CNT_W = (FRAMES > 1) ? $clog2(FRAMES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAMES - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!dev_rst_n) begin
            state_q <= SQ_OFF;
            cnt_q   <= '0;
            run_q   <= 1'b0;
        end else begin
            run_q <= 1'b1;
            case (state_q)
                SQ_OFF:  state_q <= SQ_SYNC;
                SQ_SYNC: if (frame_stb) begin
                    state_q <= SQ_COUNT;
                    cnt_q   <= '0;
                end
                SQ_COUNT: if (frame_stb) begin
                    if (cnt_q == LAST) state_q <= SQ_READY;
                    else               cnt_q   <= cnt_q + 1'b1;
                end
                default: state_q <= SQ_READY;
            endcase
        end
    end

    assign init_busy = (state_q != SQ_READY);

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!dev_rst_n)
        (state_q == SQ_READY) |=> (state_q == SQ_READY)); // R2
    AST_SYNC_NO_COUNT: assert property (@(posedge clk) disable iff (!dev_rst_n)
        (state_q == SQ_SYNC && !frame_stb) |=> (state_q == SQ_SYNC)); // R2

endmodule

// File: rtl/mode_reg.sv
module mode_reg
    import pcm_seq_pkg::*;
(
    input  logic       clk,
    input  logic       dev_rst_n,
    input  logic       init_busy,
    input  logic       wr_req,
    input  logic [1:0] wr_data,
    output logic       wr_ack,
    output mode_reg_t  mode_q
);
    assign wr_ack = wr_req & ~init_busy;

    always_ff @(posedge clk) begin
        if (!dev_rst_n || init_busy) mode_q <= MODE_DEFAULT;
        else if (wr_ack)             mode_q <= unpack_mode(wr_data);
    end

    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!dev_rst_n)
        init_busy |-> !wr_ack); // R3
    AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (!dev_rst_n)
        init_busy |=> (mode_q == MODE_DEFAULT)); // R2

endmodule

// File: rtl/frame_delay.sv
module frame_delay #(
    parameter int FRAMES = 2,
    parameter int W      = 8
) (
    input  logic         clk,
    input  logic         dev_rst_n,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int STAGES = FRAMES + 1;

    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!dev_rst_n)  stg[g] <= '0;
            else if (shift)  stg[g] <= (g == 0) ? din : stg[(g == 0) ? 0 : g - 1];
        end
    end

    assign dout = stg[STAGES-1];

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!dev_rst_n)
        !shift |=> $stable(dout)); // R7

endmodule

// File: rtl/pcm_bypass_seq.sv
module pcm_bypass_seq
    import pcm_seq_pkg::*;
(
    input  logic              clk,
    input  logic              dev_rst_n,
    input  logic              frame_stb,
    input  logic              wr_req,
    input  logic [1:0]        wr_data,
    input  logic [BYTE_W-1:0] rin_voice,
    input  logic [BYTE_W-1:0] rin_ctrl,
    input  logic [BYTE_W-1:0] sin_voice,
    input  logic [BYTE_W-1:0] sin_ctrl,
    output logic [BYTE_W-1:0] rout_voice,
    output logic [BYTE_W-1:0] rout_ctrl,
    output logic              rout_oe,
    output logic [BYTE_W-1:0] sout_voice,
    output logic [BYTE_W-1:0] sout_ctrl,
    output logic              sout_oe,
    output logic              wr_ack,
    output logic              init_busy,
    output logic              proc_clk_en,
    output logic              adapt_en,
    output logic              pass_clk_en
);
    logic      run_q;
    mode_reg_t mode_q;
    logic      shift;
    logic [BYTE_W-1:0] dl_rv, dl_rc, dl_sv, dl_sc;

    init_seq #(.FRAMES(INIT_FRAMES)) u_seq (
        .clk, .dev_rst_n, .frame_stb, .run_q, .init_busy
    );

    mode_reg u_mode (
        .clk, .dev_rst_n, .init_busy, .wr_req, .wr_data, .wr_ack, .mode_q
    );

    assign proc_clk_en = run_q & ~mode_q.bypass;
    assign adapt_en    = proc_clk_en & ~mode_q.freeze;
    assign pass_clk_en = run_q;
    assign shift       = frame_stb & proc_clk_en;

    frame_delay #(.FRAMES(VOICE_LAG), .W(BYTE_W)) u_rv (
        .clk, .dev_rst_n, .shift, .din(rin_voice), .dout(dl_rv));
    frame_delay #(.FRAMES(CTRL_LAG),  .W(BYTE_W)) u_rc (
        .clk, .dev_rst_n, .shift, .din(rin_ctrl),  .dout(dl_rc));
    frame_delay #(.FRAMES(VOICE_LAG), .W(BYTE_W)) u_sv (
        .clk, .dev_rst_n, .shift, .din(sin_voice), .dout(dl_sv));
    frame_delay #(.FRAMES(CTRL_LAG),  .W(BYTE_W)) u_sc (
        .clk, .dev_rst_n, .shift, .din(sin_ctrl),  .dout(dl_sc));

    always_comb begin
        if (!run_q) begin
            rout_voice = '0; rout_ctrl = '0;
            sout_voice = '0; sout_ctrl = '0;
        end else if (mode_q.bypass) begin
            rout_voice = rin_voice; rout_ctrl = rin_ctrl;
            sout_voice = sin_voice; sout_ctrl = sin_ctrl;
        end else begin
            rout_voice = dl_rv; rout_ctrl = dl_rc;
            sout_voice = dl_sv; sout_ctrl = dl_sc;
        end
    end

    assign rout_oe = run_q;
    assign sout_oe = run_q;

    AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (!dev_rst_n)
        mode_q.bypass |-> (rout_voice == rin_voice && sout_ctrl == sin_ctrl)); // R5
    AST_BYPASS_GATED: assert property (@(posedge clk) disable iff (!dev_rst_n)
        mode_q.bypass |-> (!shift && !adapt_en)); // R6
    AST_FREEZE_PROC: assert property (@(posedge clk) disable iff (!dev_rst_n)
        (mode_q.freeze && !mode_q.bypass && run_q) |-> (proc_clk_en && !adapt_en)); // R9
    AST_BUSY_DEFAULT: assert property (@(posedge clk) disable iff (!dev_rst_n)
        (init_busy && run_q) |-> proc_clk_en); // R3

endmodule

// File: tb/pcm_bypass_seq_tb_top.sv
module pcm_bypass_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME_CYC  = 6;

    logic clk = 1'b0;
    logic dev_rst_n, frame_stb, wr_req;
    logic [1:0] wr_data;
    logic [7:0] rin_voice, rin_ctrl, sin_voice, sin_ctrl;
    logic [7:0] rout_voice, rout_ctrl, sout_voice, sout_ctrl;
    logic rout_oe, sout_oe, wr_ack, init_busy, proc_clk_en, adapt_en, pass_clk_en;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] q_rv[$], q_rc[$], q_sv[$], q_sc[$];
    event mon_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_bypass_seq dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sb_reset();
        q_rv.delete(); q_rc.delete(); q_sv.delete(); q_sc.delete();
        repeat (2) begin q_rv.push_back(8'h00); q_sv.push_back(8'h00); end
        q_rc.push_back(8'h00); q_sc.push_back(8'h00);
    endtask

    // monitor: pops the scoreboard after each strobe edge (R7 voice, R8 control)
    always begin
        @(mon_ev);
        check("R7 rout_voice", rout_voice, q_rv.pop_front());
        check("R7 sout_voice", sout_voice, q_sv.pop_front());
        check("R8 rout_ctrl",  rout_ctrl,  q_rc.pop_front());
        check("R8 sout_ctrl",  sout_ctrl,  q_sc.pop_front());
    end

    // driver: one frame with a strobe, expected bytes pushed to the queues
    task automatic frame(input logic [7:0] rv, rc, sv, sc);
        @(negedge clk);
        rin_voice = rv; rin_ctrl = rc; sin_voice = sv; sin_ctrl = sc;
        frame_stb = 1'b1;
        q_rv.push_back(rv); q_rc.push_back(rc); q_sv.push_back(sv); q_sc.push_back(sc);
        @(negedge clk);
        frame_stb = 1'b0;
        ->mon_ev;
        repeat (FRAME_CYC - 2) @(negedge clk);
    endtask

    task automatic write(input logic [1:0] d, input logic exp_ack, input string req);
        @(negedge clk);
        wr_req = 1'b1; wr_data = d;
        #1 check(req, wr_ack, exp_ack);
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        dev_rst_n = 1'b0; frame_stb = 1'b0; wr_req = 1'b0; wr_data = 2'b00;
        rin_voice = 8'h11; rin_ctrl = 8'h22; sin_voice = 8'h33; sin_ctrl = 8'h44;
        repeat (3) @(negedge clk);
        check("R1 rout_oe", rout_oe, 0);
        check("R1 sout_oe", sout_oe, 0);
        check("R1 rout_voice", rout_voice, 0);
        check("R1 proc_clk_en", proc_clk_en, 0);
        check("R1 pass_clk_en", pass_clk_en, 0);
        check("R1 init_busy", init_busy, 1);

        dev_rst_n = 1'b1;
        sb_reset();
        @(negedge clk);
        check("R10 rout_oe", rout_oe, 1);
        check("R10 sout_oe", sout_oe, 1);
        check("R10 pass_clk_en", pass_clk_en, 1);
        check("R2 init_busy after release", init_busy, 1);

        write(2'b01, 1'b0, "R3 wr_ack while busy");
        check("R3 bypass not taken", proc_clk_en, 1);

        for (int i = 0; i < 8; i++)
            frame(8'(i * 17 + 3), 8'(i + 8'h40), 8'(8'hF0 - i * 5), 8'(i * 3));
        check("R2 busy after 8 strobes", init_busy, 1);
        frame(8'hA5, 8'h5A, 8'hC3, 8'h3C);
        check("R2 busy after 9th strobe", init_busy, 0);
        frame(8'hFF, 8'h00, 8'h00, 8'hFF);
        frame(8'h00, 8'hFF, 8'hFF, 8'h00);

        write(2'b10, 1'b1, "R4 wr_ack when ready");
        check("R9 adapt_en frozen", adapt_en, 0);
        check("R9 proc_clk_en kept", proc_clk_en, 1);
        frame(8'h81, 8'h18, 8'h7E, 8'hE7);
        frame(8'h01, 8'h02, 8'h03, 8'h04);
        frame(8'h55, 8'hAA, 8'h69, 8'h96);

        write(2'b01, 1'b1, "R4 wr_ack bypass write");
        check("R6 proc_clk_en off", proc_clk_en, 0);
        check("R6 adapt_en off", adapt_en, 0);
        check("R6 pass_clk_en on", pass_clk_en, 1);
        rin_voice = 8'h3C; rin_ctrl = 8'hD2; sin_voice = 8'h0F; sin_ctrl = 8'hB7;
        #1;
        check("R5 rout_voice", rout_voice, 8'h3C);
        check("R5 rout_ctrl", rout_ctrl, 8'hD2);
        check("R5 sout_voice", sout_voice, 8'h0F);
        check("R5 sout_ctrl", sout_ctrl, 8'hB7);
        @(negedge clk);
        rin_voice = 8'hE1; sin_ctrl = 8'h80;
        #1;
        check("R5 rout_voice second", rout_voice, 8'hE1);
        check("R5 sout_ctrl second", sout_ctrl, 8'h80);

        @(negedge clk);
        dev_rst_n = 1'b0;
        @(negedge clk);
        check("R1 rout_oe again", rout_oe, 0);
        check("R1 rout_voice again", rout_voice, 0);
        check("R1 init_busy again", init_busy, 1);
        check("R1 adapt_en again", adapt_en, 0);

        dev_rst_n = 1'b1;
        sb_reset();
        @(negedge clk);
        check("R1 bypass cleared", proc_clk_en, 1);
        write(2'b01, 1'b0, "R3 wr_ack busy again");
        frame(8'h12, 8'h34, 8'h56, 8'h78);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule